// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one start request into the column addresses of a single DRAM burst. A controller presents a starting column, the three-bit length code and the order bit from its mode setting, and pulses `start`. On the next cycle the block begins to issue one column address per clock. Each address is marked with `col_valid`, and the final one is also marked with `col_last`. The controller can end a burst early with `term`.

The block handles both address orders a DRAM supports. In sequential order the low offset counts up. In interleaved order the low offset is the start offset XORed with the beat index. In both orders the offset wraps inside an aligned block whose size equals the burst length, and the column bits above that block never change during the burst. A reserved length code is not run: the block raises a one-cycle error flag and issues no addresses. The data path and read latency are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: `len_code` 3'b001, 3'b010 and 3'b011 give bursts of 2, 4 and 8 addresses. The addresses appear one per cycle with `col_valid` high, and the first appears in the cycle after the clock edge that samples `start`.
- R2: Any other `len_code` value (3'b000, 3'b100 to 3'b111) sampled with `start` while idle raises `len_err` for exactly one cycle, the one after the start edge, and `col_valid` stays low.
- R3: With `ilv_mode` = 0, beat k has low offset (s + k) mod BL, where s is the start offset within the block.
- R4: With `ilv_mode` = 1, beat k has low offset s XOR k.
- R5: Column bits at and above position log2(BL) equal those of `start_col` on every beat of the burst.
- R6: `col_last` is high on the final beat of a burst that runs to full length, and only on that beat. `col_valid` is low in the cycle that follows.
- R7: `term` high on a cycle with `col_valid` high ends the burst. `col_valid` is low from the next cycle on, and `col_last` is not raised for that burst.
- R8: A `start` sampled while a burst is issuing is ignored. The running burst continues unchanged and `len_err` stays low.
- R9: After reset, `col_valid`, `col_last` and `len_err` are low and `col_addr` is zero.
- R10: `col_addr` is zero whenever `col_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new burst |
| start_col | input | COL_W | Starting column address |
| len_code | input | 3 | Burst length code from the mode setting |
| ilv_mode | input | 1 | Address order: 0 sequential, 1 interleaved |
| term | input | 1 | End the running burst early |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | High while `col_addr` carries a beat |
| col_last | output | 1 | Final beat of a full-length burst |
| len_err | output | 1 | One-cycle pulse for a rejected length code |

## Verification
The assertions assume that `term` is only meaningful while a burst is issuing. They also assume that `start_col`, `len_code` and `ilv_mode` matter only in the cycle `start` is sampled, so the block is never expected to track changes to them during a burst. The stimulus changes inputs only on the falling edge. It raises `start` only for one cycle at a time, and it uses `term` only in the directed early-stop case. The overlapping `start` is deliberately applied while a burst is running, to show that it is ignored.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int MAX_BEATS = 8;
    localparam int OFF_W     = $clog2(MAX_BEATS);

    typedef enum logic [1:0] {
        LEN_2   = 2'd0,
        LEN_4   = 2'd1,
        LEN_8   = 2'd2,
        LEN_BAD = 2'd3
    } blen_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        blen_e  len;
        order_e ord;
    } burst_cfg_t;

    function automatic blen_e decode_len(input logic [2:0] code);
        case (code)
            3'b001:  return LEN_2;
            3'b010:  return LEN_4;
            3'b011:  return LEN_8;
            default: return LEN_BAD;
        endcase
    endfunction

    // Mask of offset bits that wrap inside the aligned block; equals BL-1.
    function automatic logic [OFF_W-1:0] block_mask(input blen_e len);
        case (len)
            LEN_2:   return OFF_W'(1);
            LEN_4:   return OFF_W'(3);
            LEN_8:   return OFF_W'(7);
            default: return '0;
        endcase
    endfunction

    function automatic logic [OFF_W-1:0] beat_offset(
        input order_e           ord,
        input logic [OFF_W-1:0] first,
        input logic [OFF_W-1:0] beat,
        input logic [OFF_W-1:0] mask
    );
        logic [OFF_W-1:0] raw;
        raw = (ord == ORD_ILV) ? (first ^ beat) : (first + beat);
        return raw & mask;
    endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
    import burst_seq_pkg::*;
(
    input  logic [2:0]       len_code,
    input  logic             ilv_mode,
    output burst_cfg_t       cfg,
    output logic [OFF_W-1:0] mask,
    output logic             bad
);
    always_comb begin
        cfg.len = decode_len(len_code);
        cfg.ord = ilv_mode ? ORD_ILV : ORD_SEQ;
        mask    = block_mask(cfg.len);
        bad     = (cfg.len == LEN_BAD);
    end

    always_comb begin
        if (!bad) assert ($countones(mask) >= 1)
            else $error("p_mask_nonzero_r1: legal length gave empty mask");
    end
endmodule

// File: rtl/bseq_counter.sv
module bseq_counter
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             term,
    input  logic [OFF_W-1:0] lim_in,
    output logic             active,
    output logic [OFF_W-1:0] beat,
    output logic             at_end
);
    logic [OFF_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            beat   <= '0;
            lim_q  <= '0;
        end else if (launch && !active) begin
            active <= 1'b1;
            beat   <= '0;
            lim_q  <= lim_in;
        end else if (active) begin
            if (term || beat == lim_q) begin
                active <= 1'b0;
                beat   <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    assign at_end = active && (beat == lim_q) && !term;

    p_beat_bound_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> beat <= lim_q);

    p_term_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (active && term) |=> !active);

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (active && !term && beat != lim_q) |=> (active && beat == $past(beat) + 1'b1));
endmodule

// File: rtl/bseq_addr.sv
module bseq_addr
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
)(
    input  logic [COL_W-1:0] base,
    input  logic [OFF_W-1:0] mask,
    input  logic [OFF_W-1:0] offset,
    output logic [COL_W-1:0] col
);
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < OFF_W) begin : g_low
            assign col[i] = mask[i] ? offset[i] : base[i];
        end else begin : g_high
            assign col[i] = base[i];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             ilv_mode,
    input  logic             term,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             len_err
);
    burst_cfg_t       dec_cfg;
    logic [OFF_W-1:0] dec_mask;
    logic             dec_bad;

    logic [COL_W-1:0] base_q;
    logic [OFF_W-1:0] mask_q;
    order_e           ord_q;

    logic             active;
    logic [OFF_W-1:0] beat;
    logic             at_end;
    logic             launch;
    logic [OFF_W-1:0] offset;
    logic [COL_W-1:0] col_raw;

    bseq_decode u_dec (
        .len_code (len_code),
        .ilv_mode (ilv_mode),
        .cfg      (dec_cfg),
        .mask     (dec_mask),
        .bad      (dec_bad)
    );

    assign launch = start && !active && !dec_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            mask_q  <= '0;
            ord_q   <= ORD_SEQ;
            len_err <= 1'b0;
        end else begin
            len_err <= start && !active && dec_bad;
            if (launch) begin
                base_q <= start_col;
                mask_q <= dec_mask;
                ord_q  <= dec_cfg.ord;
            end
        end
    end

    bseq_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .term   (term),
        .lim_in (dec_mask),
        .active (active),
        .beat   (beat),
        .at_end (at_end)
    );

    assign offset = beat_offset(ord_q, base_q[OFF_W-1:0], beat, mask_q);

    bseq_addr #(.COL_W(COL_W)) u_addr (
        .base   (base_q),
        .mask   (mask_q),
        .offset (offset),
        .col    (col_raw)
    );

    assign col_valid = active;
    assign col_last  = at_end;
    assign col_addr  = active ? col_raw : '0;

    p_err_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        len_err |-> !col_valid);

    p_block_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        (col_valid && $past(col_valid)) |-> col_addr[COL_W-1:OFF_W] == $past(col_addr[COL_W-1:OFF_W]));

    p_last_ends_r6: assert property (@(posedge clk) disable iff (rst)
        col_last |=> !col_valid);

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !term) |=> (col_valid && !len_err));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !col_valid |-> col_addr == '0);
endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [2:0]       len_code = 3'b000;
    logic             ilv_mode = 1'b0;
    logic             term = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;
    logic             len_err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .ilv_mode(ilv_mode), .term(term),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .len_err(len_err)
    );

    // {start column, length code, order bit}
    localparam logic [13:0] VEC [10] = '{
        {10'h005, 3'b011, 1'b0}, {10'h005, 3'b011, 1'b1},
        {10'h2A6, 3'b010, 1'b0}, {10'h2A6, 3'b010, 1'b1},
        {10'h3FF, 3'b001, 1'b0}, {10'h3FF, 3'b001, 1'b1},
        {10'h1F3, 3'b011, 1'b1}, {10'h100, 3'b000, 1'b0},
        {10'h07E, 3'b110, 1'b1}, {10'h0C1, 3'b010, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 0;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] ref_col(input logic [COL_W-1:0] s, input int n,
                                                 input bit ilv, input int k);
        logic [COL_W-1:0] m, off;
        m   = COL_W'(n - 1);
        off = ilv ? (s ^ COL_W'(k)) : (s + COL_W'(k));
        return (s & ~m) | (off & m);
    endfunction

    task automatic run_burst(input logic [COL_W-1:0] c, input logic [2:0] code, input bit ilv);
        int n;
        string tag;
        n = beats_of(code);
        tag = ilv ? "R4" : "R3";
        @(negedge clk);
        start = 1'b1; start_col = c; len_code = code; ilv_mode = ilv;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(len_err === 1'b1, "R2 err pulse", len_err, 1);
            chk(col_valid === 1'b0, "R2 no valid", col_valid, 0);
            @(negedge clk);
            chk(len_err === 1'b0, "R2 single cycle", len_err, 0);
            chk(col_valid === 1'b0, "R2 still idle", col_valid, 0);
        end else begin
            for (int k = 0; k < n; k++) begin
                chk(col_valid === 1'b1, "R1 valid beat", col_valid, 1);
                chk(col_addr === ref_col(c, n, ilv, k), {tag, "/R5 address"},
                    col_addr, ref_col(c, n, ilv, k));
                chk(col_last === (k == n - 1), "R6 last flag", col_last, (k == n - 1));
                @(negedge clk);
            end
            chk(col_valid === 1'b0, "R6 idle after last", col_valid, 0);
            chk(col_addr === '0, "R10 zero when idle", col_addr, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(col_valid === 1'b0, "R9 valid", col_valid, 0);
        chk(col_last === 1'b0, "R9 last", col_last, 0);
        chk(len_err === 1'b0, "R9 err", len_err, 0);
        chk(col_addr === '0, "R9 addr", col_addr, 0);
        rst = 1'b0;

        foreach (VEC[i]) run_burst(VEC[i][13:4], VEC[i][3:1], VEC[i][0]);

        // R7: early stop after three beats
        @(negedge clk);
        start = 1'b1; start_col = 10'h0A3; len_code = 3'b011; ilv_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(col_addr === ref_col(10'h0A3, 8, 0, k), "R7 pre-stop addr",
                col_addr, ref_col(10'h0A3, 8, 0, k));
            chk(col_last === 1'b0, "R7 no last", col_last, 0);
            if (k == 2) term = 1'b1;
            @(negedge clk);
        end
        term = 1'b0;
        chk(col_valid === 1'b0, "R7 stopped", col_valid, 0);
        chk(col_last === 1'b0, "R7 no last after stop", col_last, 0);
        chk(col_addr === '0, "R10 zero after stop", col_addr, 0);

        // R8: start during a burst is ignored
        @(negedge clk);
        start = 1'b1; start_col = 10'h012; len_code = 3'b010; ilv_mode = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(col_addr === ref_col(10'h012, 4, 0, k), "R8 burst intact",
                col_addr, ref_col(10'h012, 4, 0, k));
            chk(len_err === 1'b0, "R8 no error", len_err, 0);
            chk(col_last === (k == 3), "R8 last", col_last, (k == 3));
            start = (k == 1);
            start_col = 10'h3F8; len_code = (k == 1) ? 3'b111 : 3'b011; ilv_mode = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        chk(col_valid === 1'b0, "R8 no restart", col_valid, 0);
        chk(len_err === 1'b0, "R8 no late error", len_err, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule